// File: doc/BRIEF.md
# Line-Cycle Energy Accumulator

This block integrates a stream of per-sample power values over a window that spans a programmed whole number of mains half cycles. A zero-crossing detector upstream supplies one pulse per half cycle. Because the window always begins and ends on a crossing, energy figures for different quantities taken over the same window line up exactly. This makes the block the basis for calibration and for power-factor arithmetic done elsewhere.

The host writes an unsigned 16-bit half-cycle count. The write discards any partial sum and places the controller in its waiting state. The first zero crossing after the write opens a window. From then on the block sums samples until the programmed number of further crossings has arrived. It then copies the upper bits of the wide sum into a result register, sets a sticky end-of-window flag, and starts the next window at once. A mode input selects which value is summed: apparent power, or an RMS current value that gives an ampere-hour figure. Nothing else in the path changes with the mode. If the sum would overflow within a window, it clamps at its maximum.

The controller has three states. ST_IDLE holds the block when the count is zero. ST_ARM waits for the opening crossing. ST_RUN sums samples and counts crossings. The transitions are:
- A count write goes to ST_IDLE when the value is zero and to ST_ARM otherwise, from any state.
- ST_ARM goes to ST_RUN on a crossing.
- ST_RUN stays in ST_RUN on every crossing. The crossing that completes the count closes the window and restarts the half-cycle counter.

Top module: `lcyc_energy_acc`

## Requirements
- R1: After reset, `result` is 0, `cyc_flag` is 0 and `irq` is 0, and the programmed count is 0.
- R2: With a nonzero count N written, the first `zc_pulse` after the write opens a window and the Nth `zc_pulse` after that one closes it. `result` and `cyc_flag` take their new values on the clock edge that ends the closing pulse's cycle.
- R3: `result` equals bits [ACC_W-1 : ACC_W-RES_W] of the sum of the selected sample over every cycle with `smp_valid` high, from the cycle after the opening crossing up to and including the closing crossing's cycle. Samples taken while waiting for the opening crossing are ignored.
- R4: Windows follow one another without a gap. The sample on the cycle after a closing crossing is the first one of the next window, and each window's sum starts from zero.
- R5: A count write discards the partial sum and any pending crossing in the same cycle. The block then waits for a fresh opening crossing, so the first window that completes after the write covers only samples taken after that crossing.
- R6: While the programmed count is zero, crossings and samples have no effect: no window completes, `cyc_flag` stays low and `result` keeps its value.
- R7: `cyc_flag` is sticky. A `flag_clr` pulse clears it on the next edge. When a window closes in the same cycle as `flag_clr`, the flag stays set.
- R8: `irq` is high exactly when `cyc_flag` is high and `irq_en` is high.
- R9: With `amp_mode` at 0, the summed sample is `app_pwr`. With `amp_mode` at 1, it is `irms`. The selection applies to each sample individually.
- R10: If the sum within a window would exceed 2^ACC_W-1, it stays at 2^ACC_W-1, so `result` reads all ones for that window.
- R11: `result` changes only on the edge that closes a window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_wr | input | 1 | Write strobe for the half-cycle count |
| cnt_wdata | input | 16 | Half-cycle count value |
| zc_pulse | input | 1 | One-cycle pulse per zero crossing |
| smp_valid | input | 1 | A power sample is present this cycle |
| app_pwr | input | PWR_W | Apparent power sample, unsigned |
| irms | input | PWR_W | RMS current sample, unsigned |
| amp_mode | input | 1 | 1 selects `irms`, 0 selects `app_pwr` |
| irq_en | input | 1 | Interrupt enable for the end-of-window flag |
| flag_clr | input | 1 | Write-one-to-clear pulse for `cyc_flag` |
| result | output | RES_W | Energy total of the last completed window |
| cyc_flag | output | 1 | Sticky end-of-window flag |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with 16-bit samples, a 24-bit sum and a 16-bit result, so the result is the sum shifted right by 8. With these sizes, about 256 full-scale samples reach the saturation clamp, which puts R10 inside a short directed window. Half-cycle counts of 1 to 4 with crossings a few cycles apart complete hundreds of windows in the random phase. In that phase, count rewrites land mid-window and in the same cycle as crossings, flag clears coincide with window ends, and the mode and enable inputs toggle between samples.

// File: rtl/lcyc_pkg.sv
package lcyc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ARM  = 2'd1,
        ST_RUN  = 2'd2
    } lc_state_e;

endpackage

// File: rtl/lcyc_ctrl.sv
module lcyc_ctrl
    import lcyc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] cnt_wdata,
    input  logic             zc_pulse,
    output logic             acc_clr,
    output logic             acc_en,
    output logic             win_end
);

    lc_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] hc_q, hc_d;
    logic [CNT_W:0]   hc_inc;

    assign hc_inc = {1'b0, hc_q} + {{CNT_W{1'b0}}, 1'b1};

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            hc_q    <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            hc_q    <= hc_d;
        end
    end

    // next state and outputs
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        hc_d    = hc_q;
        acc_clr = 1'b0;
        win_end = 1'b0;
        acc_en  = 1'b0;
        if (cnt_wr) begin
            cnt_d   = cnt_wdata;
            hc_d    = '0;
            acc_clr = 1'b1;
            state_d = (cnt_wdata == '0) ? ST_IDLE : ST_ARM;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    state_d = ST_IDLE;
                end
                ST_ARM: begin
                    if (zc_pulse) begin
                        state_d = ST_RUN;
                        hc_d    = '0;
                        acc_clr = 1'b1;
                    end
                end
                ST_RUN: begin
                    acc_en = 1'b1;
                    if (zc_pulse) begin
                        if (hc_inc == {1'b0, cnt_q}) begin
                            win_end = 1'b1;
                            hc_d    = '0;
                        end else begin
                            hc_d = hc_inc[CNT_W-1:0];
                        end
                    end
                end
                default: begin
                    state_d = ST_IDLE;
                end
            endcase
        end
    end

    // R6
    zero_cnt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == '0) |-> (state_q == ST_IDLE));

    // R2
    end_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_end |-> (state_q == ST_RUN));

    // R2
    hc_below_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN) |-> (hc_q < cnt_q));

    // R5
    write_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_wr && cnt_wdata != '0) |=> (state_q == ST_ARM));

endmodule

// File: rtl/lcyc_accum.sv
module lcyc_accum #(
    parameter int PWR_W = 24,
    parameter int ACC_W = 48,
    parameter int RES_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_clr,
    input  logic             acc_en,
    input  logic             win_end,
    input  logic             smp_valid,
    input  logic             amp_mode,
    input  logic [PWR_W-1:0] app_pwr,
    input  logic [PWR_W-1:0] irms,
    output logic [RES_W-1:0] result
);

    localparam int PAD_W = ACC_W + 1 - PWR_W;

    logic [ACC_W-1:0] acc_q;
    logic [RES_W-1:0] res_q;
    logic [PWR_W-1:0] smp_sel;
    logic [PWR_W-1:0] add_val;
    logic [ACC_W:0]   sum_ext;
    logic [ACC_W-1:0] sum_sat;

    assign smp_sel = amp_mode ? irms : app_pwr;
    assign add_val = (acc_en && smp_valid) ? smp_sel : '0;
    assign sum_ext = {1'b0, acc_q} + {{PAD_W{1'b0}}, add_val};
    assign sum_sat = sum_ext[ACC_W] ? {ACC_W{1'b1}} : sum_ext[ACC_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
            res_q <= '0;
        end else begin
            if (acc_clr || win_end) begin
                acc_q <= '0;
            end else begin
                acc_q <= sum_sat;
            end
            if (win_end) begin
                res_q <= sum_sat[ACC_W-1 -: RES_W];
            end
        end
    end

    assign result = res_q;

    // R10
    no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_clr && !win_end) |=> (acc_q >= $past(acc_q)));

    // R5
    clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_clr |=> (acc_q == '0));

    // R11
    res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !win_end |=> $stable(res_q));

endmodule

// File: rtl/lcyc_status.sv
module lcyc_status (
    input  logic clk,
    input  logic rst_n,
    input  logic win_end,
    input  logic flag_clr,
    input  logic irq_en,
    output logic cyc_flag,
    output logic irq
);

    logic flag_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (win_end) begin
            flag_q <= 1'b1;
        end else if (flag_clr) begin
            flag_q <= 1'b0;
        end
    end

    assign cyc_flag = flag_q;
    assign irq      = flag_q & irq_en;

    // R7
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_end |=> flag_q);

    // R7
    clr_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !win_end) |=> !flag_q);

    // R7
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(flag_q) && !$past(flag_clr)) |-> flag_q);

endmodule

// File: rtl/lcyc_energy_acc.sv
module lcyc_energy_acc #(
    parameter int PWR_W = 24,
    parameter int ACC_W = 48,
    parameter int RES_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_wr,
    input  logic [15:0]      cnt_wdata,
    input  logic             zc_pulse,
    input  logic             smp_valid,
    input  logic [PWR_W-1:0] app_pwr,
    input  logic [PWR_W-1:0] irms,
    input  logic             amp_mode,
    input  logic             irq_en,
    input  logic             flag_clr,
    output logic [RES_W-1:0] result,
    output logic             cyc_flag,
    output logic             irq
);

    localparam int CNT_W = 16;

    logic acc_clr;
    logic acc_en;
    logic win_end;

    lcyc_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cnt_wr    (cnt_wr),
        .cnt_wdata (cnt_wdata),
        .zc_pulse  (zc_pulse),
        .acc_clr   (acc_clr),
        .acc_en    (acc_en),
        .win_end   (win_end)
    );

    lcyc_accum #(.PWR_W(PWR_W), .ACC_W(ACC_W), .RES_W(RES_W)) u_accum (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_clr   (acc_clr),
        .acc_en    (acc_en),
        .win_end   (win_end),
        .smp_valid (smp_valid),
        .amp_mode  (amp_mode),
        .app_pwr   (app_pwr),
        .irms      (irms),
        .result    (result)
    );

    lcyc_status u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .win_end  (win_end),
        .flag_clr (flag_clr),
        .irq_en   (irq_en),
        .cyc_flag (cyc_flag),
        .irq      (irq)
    );

    // R8
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (cyc_flag && irq_en));

    // R6
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_wr && cnt_wdata == 16'd0) |=> !win_end);

endmodule

// File: tb/lcyc_energy_acc_tb.sv
`timescale 1ns/1ps
module lcyc_energy_acc_tb;

    localparam int PW = 16;
    localparam int AW = 24;
    localparam int RW = 16;
    localparam longint SMAX = (64'd1 << AW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cnt_wr = 1'b0;
    logic [15:0]   cnt_wdata = '0;
    logic          zc_pulse = 1'b0;
    logic          smp_valid = 1'b0;
    logic [PW-1:0] app_pwr = '0;
    logic [PW-1:0] irms = '0;
    logic          amp_mode = 1'b0;
    logic          irq_en = 1'b0;
    logic          flag_clr = 1'b0;
    logic [RW-1:0] result;
    logic          cyc_flag;
    logic          irq;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    // reference model state
    int     m_st = 0;
    int     m_cnt = 0;
    int     m_hc = 0;
    longint m_acc = 0;
    int     m_res = 0;
    bit     m_flag = 0;

    always #2.5 clk = ~clk;

    lcyc_energy_acc #(.PWR_W(PW), .ACC_W(AW), .RES_W(RW)) u_dut (
        .clk(clk), .rst_n(rst_n), .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
        .zc_pulse(zc_pulse), .smp_valid(smp_valid), .app_pwr(app_pwr),
        .irms(irms), .amp_mode(amp_mode), .irq_en(irq_en), .flag_clr(flag_clr),
        .result(result), .cyc_flag(cyc_flag), .irq(irq)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic longint sat_add(input longint a, input longint b);
        return (a + b > SMAX) ? SMAX : a + b;
    endfunction

    task automatic model_step();
        bit set = 0;
        longint add;
        if (cnt_wr) begin
            m_cnt = cnt_wdata; m_hc = 0; m_acc = 0;
            m_st = (cnt_wdata == 0) ? 0 : 1;
        end else if (m_st == 1) begin
            if (zc_pulse) begin m_st = 2; m_hc = 0; m_acc = 0; end
        end else if (m_st == 2) begin
            add = smp_valid ? longint'(amp_mode ? irms : app_pwr) : 0;
            m_acc = sat_add(m_acc, add);
            if (zc_pulse) begin
                if (m_hc + 1 == m_cnt) begin
                    m_res = int'(m_acc >> (AW - RW));
                    set = 1; m_acc = 0; m_hc = 0;
                end else m_hc++;
            end
        end
        if (set) m_flag = 1;
        else if (flag_clr) m_flag = 0;
    endtask

    // one clock: inputs already driven; model updated; outputs checked at negedge
    task automatic cyc();
        @(posedge clk);
        model_step();
        @(negedge clk);
        chk("R3 result", result, m_res);
        chk("R7 cyc_flag", cyc_flag, m_flag);
        chk("R8 irq", irq, m_flag & irq_en);
        cnt_wr = 0; zc_pulse = 0; flag_clr = 0; smp_valid = 0;
    endtask

    task automatic smp(input int v);
        smp_valid = 1; app_pwr = PW'(v); cyc();
    endtask

    initial begin
        #750000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 result", result, 0);
        chk("R1 flag", cyc_flag, 0);
        chk("R1 irq", irq, 0);
        rst_n = 1;
        irq_en = 1;

        // R6: count zero, crossings and samples change nothing
        for (int k = 0; k < 20; k++) begin
            zc_pulse = (k % 3 == 0); smp_valid = 1; app_pwr = 16'hFFFF; cyc();
        end
        chk("R6 flag idle", cyc_flag, 0);
        chk("R6 result idle", result, 0);

        // R2 R3: count 2, ARM samples ignored
        cnt_wr = 1; cnt_wdata = 2; cyc();
        smp(16'h0100); smp(16'h0100);
        zc_pulse = 1; smp(16'h0100);           // opening crossing, sample ignored
        smp(16'h0100); smp(16'h0100); smp(16'h0100);
        zc_pulse = 1; smp(16'h0100);           // first crossing inside window
        smp(16'h0200); smp(16'h0200);
        chk("R2 flag before close", cyc_flag, 0);
        zc_pulse = 1; cyc();                   // closing crossing
        chk("R2 flag on close", cyc_flag, 1);
        chk("R3 result value", result, 16'h0008);
        chk("R8 irq on", irq, 1);
        irq_en = 0; cyc();
        chk("R8 irq masked", irq, 0);

        // R4: next window started right away, continues with count 2
        smp(16'h0400); zc_pulse = 1; cyc(); zc_pulse = 1; cyc();
        chk("R4 back-to-back", result, 16'h0004);

        // R7: clear, then clear coinciding with close
        flag_clr = 1; cyc();
        chk("R7 cleared", cyc_flag, 0);
        zc_pulse = 1; cyc();
        zc_pulse = 1; flag_clr = 1; cyc();
        chk("R7 set wins", cyc_flag, 1);
        flag_clr = 1; cyc();

        // R9: current mode, count 1
        cnt_wr = 1; cnt_wdata = 1; cyc();
        zc_pulse = 1; cyc();
        amp_mode = 1; irms = 16'h0500; app_pwr = 16'h7777;
        smp_valid = 1; cyc(); smp_valid = 1; cyc();
        amp_mode = 0; app_pwr = 16'h0100; smp_valid = 1; cyc();
        zc_pulse = 1; cyc();
        chk("R9 mode select", result, 16'h000B);

        // R5: rewrite mid-window discards partial sum
        smp(16'h1000); smp(16'h1000); smp(16'h1000);
        cnt_wr = 1; cnt_wdata = 1; zc_pulse = 1; smp(16'h1000);
        smp(16'h0100); smp(16'h0100);
        zc_pulse = 1; cyc();
        smp(16'h0300);
        zc_pulse = 1; cyc();
        chk("R5 restart result", result, 16'h0003);

        // R10: saturation
        for (int k = 0; k < 300; k++) smp(16'hFFFF);
        zc_pulse = 1; cyc();
        chk("R10 saturated", result, 16'hFFFF);
        smp(16'h0100); zc_pulse = 1; cyc();
        chk("R10 fresh after sat", result, 16'h0001);

        // random phase against the model
        for (int k = 0; k < 6000; k++) begin
            if ($urandom_range(0, 199) == 0) begin
                cnt_wr = 1; cnt_wdata = 16'($urandom_range(0, 4));
            end
            if ($urandom_range(0, 19) == 0) begin
                cnt_wr = 1; cnt_wdata = 16'($urandom_range(1, 4));
            end
            zc_pulse  = ($urandom_range(0, 5) == 0);
            smp_valid = ($urandom_range(0, 3) != 0);
            app_pwr   = PW'($urandom);
            irms      = PW'($urandom);
            if ($urandom_range(0, 7) == 0) amp_mode = ~amp_mode;
            if ($urandom_range(0, 15) == 0) irq_en = ~irq_en;
            flag_clr  = ($urandom_range(0, 9) == 0);
            cyc();
        end

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule